// File: doc/BRIEF.md
# Partitioned Tagless Instruction Cache

This block is a first-level instruction cache split into several sub-caches, each exactly one virtual page in size and direct-mapped with 32-byte lines. A sub-cache has no tag storage. Each sub-cache is permanently paired with one micro TLB entry, so the entry number that the TLB reports for a fetch is also the sub-cache that must hold the line. The line inside the page is picked by the page-offset bits of the virtual address. The cache keeps a register with the id of the most recently used sub-cache. A new fetch reads only that sub-cache while the TLB lookup runs in parallel.

When the TLB hits and its entry id equals the predicted id, the answer comes back one cycle after the request is taken. When the ids differ, the block spends one extra cycle reading the correct sub-cache, and it lowers its ready signal during that cycle. A TLB miss is always reported as a cache miss. The TLB reports the entry it is replacing, and the sub-cache paired with that entry is emptied in one cycle. Lines are written by a refill port. Each line carries one flag that marks it both as holding data and as powered. The flag is cleared at reset and by a flush, and set by a refill.

Top module: `picache`

## Requirements
- R1: After reset, every line flag in `line_on` is 0, `resp_valid` and `resp_hit` are 0, `resp_data` is 0 and `fetch_ready` is 1. The predicted sub-cache is 0.
- R2: A fetch is taken when `fetch_valid` and `fetch_ready` are both high at a clock edge. If `tlb_hit` is 1 and `tlb_id` equals the predicted id, `resp_valid` is high for exactly the following cycle with `resp_penalty` 0, and `fetch_ready` stays 1.
- R3: A fetch whose line flag is 0 returns `resp_hit` 0.
- R4: If `tlb_hit` is 1 and `tlb_id` differs from the predicted id, `fetch_ready` is 0 for exactly the next cycle. `resp_valid` and `resp_penalty` are then high in the cycle after that, and the hit and data come from sub-cache `tlb_id`.
- R5: After every taken fetch, the predicted id becomes `tlb_id`. This holds for hits, mispredicts and TLB misses alike, so a following fetch with the same `tlb_id` and a TLB hit has `resp_penalty` 0.
- R6: A taken fetch with `tlb_hit` 0 gives `resp_valid` 1, `resp_hit` 0 and `resp_penalty` 0 in the next cycle. It also clears every flag of sub-cache `tlb_id`, and leaves the other sub-caches unchanged.
- R7: A refill (`refill_valid` high at an edge) stores `refill_line` and sets flag `line_on[refill_sub*128 + refill_index]`. A later hit returns the 32-bit word `refill_line[w*32 +: 32]`, where w is the word offset.
- R8: The line index is `fetch_vaddr[11:5]` and the word offset is `fetch_vaddr[4:2]`. Address bits above bit 11 play no part in the lookup, because no tag is compared.
- R9: If a flush and a refill target the same sub-cache in one cycle, the refilled line ends up with its flag set and every other line of that sub-cache ends up cleared.
- R10: While `fetch_ready` is 0, `fetch_valid` is ignored. No further response is produced for a request held during the penalty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch request present |
| fetch_vaddr | input | ADDR_W (32) | Virtual fetch address |
| fetch_ready | output | 1 | Block can take a fetch this cycle |
| tlb_hit | input | 1 | Micro TLB result for the current fetch: 1 = hit |
| tlb_id | input | ID_W (2) | Matching entry on a hit, replaced entry on a miss |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Requested line was present |
| resp_penalty | output | 1 | Response took the extra mispredict cycle |
| resp_data | output | WORD_W (32) | Fetched word, 0 when not a hit |
| refill_valid | input | 1 | Write one line |
| refill_sub | input | ID_W (2) | Sub-cache to write |
| refill_index | input | IDX_W (7) | Line within the sub-cache |
| refill_line | input | LINE_W (256) | Line contents, word 0 in the low bits |
| line_on | output | NUM_SUB*LINES (512) | Per-line flag; bit s*LINES+i for line i of sub-cache s |

## Verification
The hardest case to reach is a flush and a refill hitting the same sub-cache in the same cycle. In normal use the refill comes well after the miss that started it. The bench forces this case by driving a TLB-miss fetch and a refill to the victim sub-cache on the same falling edge, then reading the flag map. The bench also steers the prediction register through a sequence of hits, mispredicts and TLB misses. This shows that the register follows the resolved id every time, which can be seen from the presence or absence of the penalty cycle. While the penalty cycle is running, the bench changes the held request to prove that it is ignored.

// File: rtl/picache_pkg.sv
package picache_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_PEN = 1'b1
  } picache_state_t;
endpackage

// File: rtl/picache_predictor.sv
module picache_predictor #(
  parameter int NUM_SUB = 4,
  localparam int ID_W = $clog2(NUM_SUB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [ID_W-1:0] load_id,
  input  logic            tlb_hit,
  input  logic [ID_W-1:0] tlb_id,
  output logic [ID_W-1:0] pred_id,
  output logic            pred_ok
);
  logic [ID_W-1:0] pred_q, pred_d;

  always_comb begin
    pred_d = pred_q;
    if (load_en) pred_d = load_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= '0;
    else        pred_q <= pred_d;
  end

  assign pred_id = pred_q;
  assign pred_ok = tlb_hit && (tlb_id == pred_q);
endmodule

// File: rtl/picache_flags.sv
module picache_flags #(
  parameter int NUM_SUB = 4,
  parameter int LINES   = 128,
  localparam int ID_W   = $clog2(NUM_SUB),
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_en,
  input  logic [ID_W-1:0]          flush_sub,
  input  logic                     wr_en,
  input  logic [ID_W-1:0]          wr_sub,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [ID_W-1:0]          rd_sub,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_on,
  output logic [NUM_SUB*LINES-1:0] on_map
);
  // One flag per line: set means data present and line powered.
  logic [NUM_SUB-1:0][LINES-1:0] on_q, on_d;

  always_comb begin
    on_d = on_q;
    if (flush_en) on_d[flush_sub] = '0;
    // A refill is applied after a same-cycle flush so its line survives.
    if (wr_en) on_d[wr_sub][wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= '0;
    else        on_q <= on_d;
  end

  assign rd_on  = on_q[rd_sub][rd_idx];
  assign on_map = on_q;

  // R6: a flush alone leaves the whole sub-cache dark
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !(wr_en && (wr_sub == flush_sub))) |=> (on_q[$past(flush_sub)] == '0));

  // R9: flush plus refill to the same sub-cache keeps exactly the refilled line
  a_r9_flush_refill_same: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && wr_en && (wr_sub == flush_sub)) |=>
      (($countones(on_q[$past(flush_sub)]) == 1) && on_q[$past(wr_sub)][$past(wr_idx)]));

  // R7: a refilled line is powered afterwards
  a_r7_refill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> on_q[$past(wr_sub)][$past(wr_idx)]);
endmodule

// File: rtl/picache_data.sv
module picache_data #(
  parameter int NUM_SUB = 4,
  parameter int LINES   = 128,
  parameter int LINE_W  = 256,
  localparam int ID_W   = $clog2(NUM_SUB),
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_sub,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   rd_sub,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] sub_rd [NUM_SUB];
  logic [LINE_W-1:0] rd_q, rd_d;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    logic [LINE_W-1:0] store [LINES];
    logic              sub_wr;

    assign sub_wr = wr_en && (wr_sub == ID_W'(g));

    always_ff @(posedge clk) begin
      if (sub_wr) store[wr_idx] <= wr_line;
    end

    assign sub_rd[g] = store[rd_idx];
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = sub_rd[rd_sub];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_line = rd_q;
endmodule

// File: rtl/picache.sv
module picache #(
  parameter int NUM_SUB    = 4,
  parameter int PAGE_BYTES = 4096,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32,
  localparam int ID_W      = $clog2(NUM_SUB),
  localparam int LINES     = PAGE_BYTES / LINE_BYTES,
  localparam int IDX_W     = $clog2(LINES),
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BYTE_W    = $clog2(WORD_BYTES),
  localparam int WOFF_W    = OFF_W - BYTE_W,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int LINE_W    = 8 * LINE_BYTES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_valid,
  input  logic [ADDR_W-1:0]        fetch_vaddr,
  output logic                     fetch_ready,
  input  logic                     tlb_hit,
  input  logic [ID_W-1:0]          tlb_id,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic                     resp_penalty,
  output logic [WORD_W-1:0]        resp_data,
  input  logic                     refill_valid,
  input  logic [ID_W-1:0]          refill_sub,
  input  logic [IDX_W-1:0]         refill_index,
  input  logic [LINE_W-1:0]        refill_line,
  output logic [NUM_SUB*LINES-1:0] line_on
);
  import picache_pkg::*;

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  picache_state_t    state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WOFF_W-1:0] word_q, word_d;
  logic              rv_q, rv_d;
  logic              rh_q, rh_d;
  logic              rp_q, rp_d;

  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_word;
  logic              accept;
  logic              flush_en;
  logic [ID_W-1:0]   pred_id;
  logic              pred_ok;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_on;
  logic [LINE_W-1:0] rd_line;

  assign req_idx     = fetch_vaddr[PAGE_W-1:OFF_W];
  assign req_word    = fetch_vaddr[OFF_W-1:BYTE_W];
  assign fetch_ready = (state_q == ST_RUN);
  assign accept      = fetch_valid && fetch_ready;
  assign flush_en    = accept && !tlb_hit;

  // The predictor is loaded when the fetch is taken. In the penalty cycle
  // it already holds the resolved id, so it also addresses the re-read.
  assign rd_en  = accept || (state_q == ST_PEN);
  assign rd_idx = (state_q == ST_PEN) ? idx_q : req_idx;

  picache_predictor #(.NUM_SUB(NUM_SUB)) u_pred (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load_en (accept),
    .load_id (tlb_id),
    .tlb_hit (tlb_hit),
    .tlb_id  (tlb_id),
    .pred_id (pred_id),
    .pred_ok (pred_ok)
  );

  picache_flags #(.NUM_SUB(NUM_SUB), .LINES(LINES)) u_flags (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .flush_en  (flush_en),
    .flush_sub (tlb_id),
    .wr_en     (refill_valid),
    .wr_sub    (refill_sub),
    .wr_idx    (refill_index),
    .rd_sub    (pred_id),
    .rd_idx    (rd_idx),
    .rd_on     (rd_on),
    .on_map    (line_on)
  );

  picache_data #(.NUM_SUB(NUM_SUB), .LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (refill_valid),
    .wr_sub  (refill_sub),
    .wr_idx  (refill_index),
    .wr_line (refill_line),
    .rd_en   (rd_en),
    .rd_sub  (pred_id),
    .rd_idx  (rd_idx),
    .rd_line (rd_line)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    word_d  = word_q;
    rv_d    = 1'b0;
    rh_d    = 1'b0;
    rp_d    = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (accept) begin
          idx_d  = req_idx;
          word_d = req_word;
          if (tlb_hit && !pred_ok) begin
            state_d = ST_PEN;
          end else begin
            rv_d = 1'b1;
            rh_d = tlb_hit && rd_on;
          end
        end
      end
      ST_PEN: begin
        state_d = ST_RUN;
        rv_d    = 1'b1;
        rh_d    = rd_on;
        rp_d    = 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      word_q  <= '0;
      rv_q    <= 1'b0;
      rh_q    <= 1'b0;
      rp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      rv_q    <= rv_d;
      rh_q    <= rh_d;
      rp_q    <= rp_d;
    end
  end

  assign resp_valid   = rv_q;
  assign resp_hit     = rh_q;
  assign resp_penalty = rp_q;
  assign resp_data    = rh_q ? rd_line[word_q * WORD_W +: WORD_W] : '0;

  // R4: the ready gap lasts a single cycle
  a_r4_ready_gap_one: assert property (@(posedge clk) disable iff (!core_rst_n)
    !fetch_ready |=> fetch_ready);

  // R4: the penalised response follows the gap
  a_r4_penalty_resp: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(fetch_ready) |=> (resp_valid && resp_penalty));

  // R2: a correct prediction answers next cycle without penalty
  a_r2_match_no_penalty: assert property (@(posedge clk) disable iff (!core_rst_n)
    (accept && pred_ok) |=> (resp_valid && !resp_penalty && fetch_ready));

  // R6: a TLB miss is a plain miss
  a_r6_tlb_miss_resp: assert property (@(posedge clk) disable iff (!core_rst_n)
    (accept && !tlb_hit) |=> (resp_valid && !resp_hit && !resp_penalty));

  // R10: no response appears without a taken fetch or a penalty cycle
  a_r10_no_stray_resp: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!accept && fetch_ready) |=> !resp_valid);
endmodule

// File: tb/picache_test.sv
module picache_test;
  localparam int LINES = 128;

  logic         clk;
  logic         rst_n;
  logic         fetch_valid;
  logic [31:0]  fetch_vaddr;
  logic         fetch_ready;
  logic         tlb_hit;
  logic [1:0]   tlb_id;
  logic         resp_valid;
  logic         resp_hit;
  logic         resp_penalty;
  logic [31:0]  resp_data;
  logic         refill_valid;
  logic [1:0]   refill_sub;
  logic [6:0]   refill_index;
  logic [255:0] refill_line;
  logic [511:0] line_on;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  picache uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_vaddr  (fetch_vaddr),
    .fetch_ready  (fetch_ready),
    .tlb_hit      (tlb_hit),
    .tlb_id       (tlb_id),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_penalty (resp_penalty),
    .resp_data    (resp_data),
    .refill_valid (refill_valid),
    .refill_sub   (refill_sub),
    .refill_index (refill_index),
    .refill_line  (refill_line),
    .line_on      (line_on)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mkword(int s, int i, int w);
    return {8'(s), 8'(i), 8'(w), 8'hA5};
  endfunction

  function automatic logic [255:0] mkline(int s, int i);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = mkword(s, i, w);
    return l;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic refill(int s, int i);
    @(negedge clk);
    refill_valid = 1'b1;
    refill_sub   = 2'(s);
    refill_index = 7'(i);
    refill_line  = mkline(s, i);
    @(negedge clk);
    refill_valid = 1'b0;
    chk("R7", "flag set after refill", 64'(line_on[s*LINES + i]), 64'd1);
  endtask

  // Drive one fetch and check its response at the expected cycle.
  task automatic fetch(string req, logic [31:0] addr, bit th, int id,
                       bit exp_pen, bit exp_hit, logic [31:0] exp_data);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_vaddr = addr;
    tlb_hit     = th;
    tlb_id      = 2'(id);
    @(negedge clk);
    if (exp_pen) begin
      chk(req, "ready low in penalty cycle", 64'(fetch_ready), 64'd0);
      chk(req, "no response in penalty cycle", 64'(resp_valid), 64'd0);
      fetch_vaddr = addr ^ 32'h20; // held request must be ignored (R10)
      @(negedge clk);
    end
    fetch_valid = 1'b0;
    chk(req, "resp_valid", 64'(resp_valid), 64'd1);
    chk(req, "resp_penalty", 64'(resp_penalty), 64'(exp_pen));
    chk(req, "resp_hit", 64'(resp_hit), 64'(exp_hit));
    if (exp_hit) chk(req, "resp_data", 64'(resp_data), 64'(exp_data));
    chk(req, "ready after response", 64'(fetch_ready), 64'd1);
    @(negedge clk);
    chk(exp_pen ? "R10" : req, "single response", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "flags clear", 64'($countones(line_on)), 64'd0);
    chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
    chk("R1", "resp_hit", 64'(resp_hit), 64'd0);
    chk("R1", "resp_data", 64'(resp_data), 64'd0);
    chk("R1", "fetch_ready", 64'(fetch_ready), 64'd1);
  endtask

  task automatic t_basic;
    fetch("R3", 32'h0000_0040, 1'b1, 0, 1'b0, 1'b0, 32'h0);
    refill(0, 2);
    chk("R7", "only one flag", 64'($countones(line_on)), 64'd1);
    fetch("R2", 32'h0000_004C, 1'b1, 0, 1'b0, 1'b1, mkword(0, 2, 3));
    fetch("R8", 32'h7654_304C, 1'b1, 0, 1'b0, 1'b1, mkword(0, 2, 3));
  endtask

  task automatic t_mispredict;
    refill(2, 5);
    fetch("R4", 32'h0000_00A4, 1'b1, 2, 1'b1, 1'b1, mkword(2, 5, 1));
    fetch("R5", 32'h0000_00A4, 1'b1, 2, 1'b0, 1'b1, mkword(2, 5, 1));
    fetch("R4", 32'h0000_004C, 1'b1, 0, 1'b1, 1'b1, mkword(0, 2, 3));
  endtask

  task automatic t_tlb_miss;
    fetch("R6", 32'h0000_004C, 1'b0, 0, 1'b0, 1'b0, 32'h0);
    chk("R6", "victim sub-cache cleared", 64'($countones(line_on[0 +: LINES])), 64'd0);
    chk("R6", "other sub-cache kept", 64'(line_on[2*LINES + 5]), 64'd1);
    fetch("R6", 32'h0000_004C, 1'b1, 0, 1'b0, 1'b0, 32'h0);
    fetch("R5", 32'h0000_00A4, 1'b0, 2, 1'b0, 1'b0, 32'h0);
    chk("R6", "second victim cleared", 64'($countones(line_on)), 64'd0);
    fetch("R5", 32'h0000_00A4, 1'b1, 2, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_flush_refill;
    refill(1, 3);
    @(negedge clk);
    fetch_valid  = 1'b1;
    fetch_vaddr  = 32'h0000_0000;
    tlb_hit      = 1'b0;
    tlb_id       = 2'd1;
    refill_valid = 1'b1;
    refill_sub   = 2'd1;
    refill_index = 7'd7;
    refill_line  = mkline(1, 7);
    @(negedge clk);
    fetch_valid  = 1'b0;
    refill_valid = 1'b0;
    chk("R9", "miss response", 64'({resp_valid, resp_hit, resp_penalty}), 64'b100);
    chk("R9", "refilled line on", 64'(line_on[LINES + 7]), 64'd1);
    chk("R9", "older line off", 64'(line_on[LINES + 3]), 64'd0);
    chk("R9", "flag count", 64'($countones(line_on)), 64'd1);
    fetch("R7", 32'h0000_00FC, 1'b1, 1, 1'b0, 1'b1, mkword(1, 7, 7));
  endtask

  initial begin
    rst_n        = 1'b0;
    fetch_valid  = 1'b0;
    fetch_vaddr  = '0;
    tlb_hit      = 1'b0;
    tlb_id       = '0;
    refill_valid = 1'b0;
    refill_sub   = '0;
    refill_index = '0;
    refill_line  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_mispredict();
    t_tlb_miss();
    t_flush_refill();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule